// File: doc/BRIEF.md
# Text-Mode Raster Display Controller

This block turns a single pixel clock into a complete 640x480 raster with active-low horizontal and vertical sync. Inside that raster it draws an 80-column by 25-row character screen. Each cell has two parts. A screen memory holds an 8-bit character byte: the low seven bits pick one of 128 glyphs and the top bit asks for reverse video. An attribute memory holds a 4-bit foreground colour. Each glyph is 8x8 pixels. Every glyph row is drawn on two scan lines, so one text row is 16 lines tall. The 25 text rows fill the top 400 lines, and the rest of the visible area stays black.

A host writes and reads both memories through a byte-wide port, while the display keeps reading them on its own port. A cursor position input marks one cell, and that cell is shown inverted in a blinking pattern. Screen, attribute and glyph lookups run through a two-stage pipeline. Sync is delayed by the same two stages, so every pixel lines up with its sync.

Every size and timing value is a parameter. The bench uses a small raster so that it can step through several blink periods.

Top module: `txtvid_ctrl`

## Requirements
- R1: `hsync_n` is low for exactly the H_SYNC clocks that start H_VIS+H_FP clocks into each line. The line is H_VIS+H_FP+H_SYNC+H_BP clocks long. All outputs lag the internal raster position by 2 clocks; the first position after reset release appears on the outputs after the second rising edge.
- R2: `vsync_n` is low during the V_SYNC lines that start V_VIS+V_FP lines into the frame. The frame is V_VIS+V_FP+V_SYNC+V_BP lines long.
- R3: `rgb` is 0 outside the visible H_VIS x V_VIS area, and also on visible lines at or below line ROWS*16.
- R4: At visible text position (x, y), the cell index is (y/16)*COLS + x/8 and the glyph row is (y mod 16)/2. The glyph row bits are {0,code[6:0]} XOR ((row*8'h25) mod 256). Bit 7 of that result is the leftmost pixel, at x mod 8 = 0.
- R5: A lit pixel outputs the cell's 4-bit attribute value on `rgb`. An unlit pixel outputs 0.
- R6: When bit 7 of the character byte is 1, every pixel of that cell is inverted.
- R7: When the blink phase is on, the cell at (`cursor_col`, `cursor_row`) is inverted as well. Reverse video and cursor together cancel out. The phase is on for the first BLINK_FRAMES frames after reset and then toggles every BLINK_FRAMES frames.
- R8: Writing with `host_sel`=0 stores the byte in screen memory. Writing with `host_sel`=1 stores its low 4 bits in attribute memory. `host_rdata` shows the selected memory at `host_addr` one rising edge later, with attribute reads zero-extended.
- R9: During reset, `hsync_n` and `vsync_n` are 1 and `rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects screen memory, 1 selects attribute memory |
| host_addr | input | ADDR_W | Host cell address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one clock after the address |
| cursor_col | input | COL_W | Cursor column |
| cursor_row | input | ROW_W | Cursor row |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | ATTR_W | Pixel colour |

## Verification
Reverse video and the cursor overlay can both apply to the same pixel. The cursor is therefore placed on a cell whose character byte has bit 7 set. The pixels there must show the plain glyph while the blink phase is on, and the inverted glyph while it is off. The blink toggle also falls on the same clock as the frame wrap. A full model of the raster is compared pixel by pixel across five frames, with a blink period of two frames, so every transition edge is checked against the expected inversion.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;
   localparam int GLYPH_W   = 8;
   localparam int GLYPH_H   = 8;
   localparam int LINE_REP  = 2;
   localparam int GLYPHS    = 128;
   localparam int ROW_LINES = GLYPH_H * LINE_REP;

   // computed glyph pattern: one 8-pixel row of a glyph
   function automatic logic [GLYPH_W-1:0] glyph_row(input logic [6:0] code,
                                                    input logic [2:0] row);
      logic [7:0] mix;
      mix = {5'b0, row} * 8'h25;
      return {1'b0, code} ^ mix;
   endfunction
endpackage

// File: rtl/txtvid_timing.sv
module txtvid_timing #(
   parameter int H_VIS  = 640,
   parameter int H_FP   = 16,
   parameter int H_SYNC = 96,
   parameter int H_BP   = 48,
   parameter int V_VIS  = 480,
   parameter int V_FP   = 10,
   parameter int V_SYNC = 2,
   parameter int V_BP   = 33,
   parameter int HW     = 10,
   parameter int VW     = 10
)(
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          hs_n,
   output logic          vs_n,
   output logic          vis,
   output logic          frame_end
);
   localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
   localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
   localparam int HS_LO = H_VIS + H_FP;
   localparam int VS_LO = V_VIS + V_FP;

   logic h_last, v_last;

   assign h_last    = int'(hcnt) == H_TOT - 1;
   assign v_last    = int'(vcnt) == V_TOT - 1;
   assign frame_end = h_last && v_last;
   assign hs_n      = !(int'(hcnt) >= HS_LO && int'(hcnt) < HS_LO + H_SYNC);
   assign vs_n      = !(int'(vcnt) >= VS_LO && int'(vcnt) < VS_LO + V_SYNC);
   assign vis       = int'(hcnt) < H_VIS && int'(vcnt) < V_VIS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (h_last) begin
         hcnt <= '0;
         vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   AST_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
      h_last |=> hcnt == '0); // R1
   AST_VHOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !h_last |=> $stable(vcnt)); // R2
   AST_HRANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hcnt) < H_TOT); // R1
endmodule

// File: rtl/txtvid_dpram.sv
module txtvid_dpram #(
   parameter int W     = 8,
   parameter int DEPTH = 2000,
   parameter int AW    = 11
)(
   input  logic          clk,
   input  logic          we_a,
   input  logic [AW-1:0] addr_a,
   input  logic [W-1:0]  wdata_a,
   output logic [W-1:0]  rdata_a,
   input  logic [AW-1:0] addr_b,
   output logic [W-1:0]  rdata_b
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_a && int'(addr_a) < DEPTH) mem[addr_a] <= wdata_a;
      rdata_a <= mem[addr_a];
      rdata_b <= mem[addr_b];
   end
endmodule

// File: rtl/txtvid_glyph_rom.sv
module txtvid_glyph_rom
   import txtvid_pkg::*;
(
   input  logic [6:0]         code,
   input  logic [2:0]         row,
   output logic [GLYPH_W-1:0] bits
);
   assign bits = glyph_row(code, row);
endmodule

// File: rtl/txtvid_ctrl.sv
module txtvid_ctrl
   import txtvid_pkg::*;
#(
   parameter int COLS         = 80,
   parameter int ROWS         = 25,
   parameter int H_VIS        = 640,
   parameter int H_FP         = 16,
   parameter int H_SYNC       = 96,
   parameter int H_BP         = 48,
   parameter int V_VIS        = 480,
   parameter int V_FP         = 10,
   parameter int V_SYNC       = 2,
   parameter int V_BP         = 33,
   parameter int ATTR_W       = 4,
   parameter int ADDR_W       = 11,
   parameter int COL_W        = 7,
   parameter int ROW_W        = 5,
   parameter int BLINK_FRAMES = 16,
   parameter bit CURSOR_EN    = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic [COL_W-1:0]  cursor_col,
   input  logic [ROW_W-1:0]  cursor_row,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic [ATTR_W-1:0] rgb
);
   localparam int CELLS     = COLS * ROWS;
   localparam int H_TOT     = H_VIS + H_FP + H_SYNC + H_BP;
   localparam int V_TOT     = V_VIS + V_FP + V_SYNC + V_BP;
   localparam int HW        = $clog2(H_TOT);
   localparam int VW        = $clog2(V_TOT);
   localparam int TXT_LINES = ROWS * ROW_LINES;
   localparam int BW        = $clog2(BLINK_FRAMES + 1);

   // elaboration-time parameter checks
   if (H_VIS != COLS * GLYPH_W) begin : g_bad_hvis
      $error("H_VIS must equal COLS*GLYPH_W");
   end
   if (TXT_LINES > V_VIS) begin : g_bad_rows
      $error("text rows exceed visible lines");
   end
   if ((1 << ADDR_W) < CELLS) begin : g_bad_addr
      $error("ADDR_W too small for COLS*ROWS");
   end
   if ((1 << COL_W) < COLS || (1 << ROW_W) < ROWS) begin : g_bad_cur
      $error("cursor widths too small");
   end
   if (ATTR_W > 8 || BLINK_FRAMES < 1) begin : g_bad_misc
      $error("ATTR_W or BLINK_FRAMES out of range");
   end

   // ---------------- stage 0: raster position ----------------
   logic [HW-1:0]     hcnt;
   logic [VW-1:0]     vcnt;
   logic              hs0, vs0, vis0, fend;
   logic              txt0, cur0;
   logic [COL_W-1:0]  col0;
   logic [ROW_W-1:0]  row0;
   logic [2:0]        gr0, px0;
   logic [ADDR_W-1:0] addr0;

   txtvid_timing #(
      .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
      .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
      .HW(HW), .VW(VW)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .hs_n(hs0), .vs_n(vs0), .vis(vis0), .frame_end(fend)
   );

   assign txt0  = vis0 && int'(vcnt) < TXT_LINES;
   assign col0  = COL_W'(int'(hcnt) / GLYPH_W);
   assign row0  = ROW_W'(int'(vcnt) / ROW_LINES);
   assign gr0   = 3'((int'(vcnt) % ROW_LINES) / LINE_REP);
   assign px0   = hcnt[2:0];
   assign addr0 = txt0 ? ADDR_W'(int'(row0) * COLS + int'(col0)) : '0;

   // cursor overlay variant
   if (CURSOR_EN) begin : g_cursor
      logic          blink_q;
      logic [BW-1:0] fcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            blink_q <= 1'b1;
            fcnt    <= '0;
         end else if (fend) begin
            if (int'(fcnt) == BLINK_FRAMES - 1) begin
               fcnt    <= '0;
               blink_q <= ~blink_q;
            end else begin
               fcnt <= fcnt + 1'b1;
            end
         end
      end
      assign cur0 = blink_q && txt0 && col0 == cursor_col && row0 == cursor_row;

      AST_BLINK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(blink_q) |-> $past(fend)); // R7
   end else begin : g_no_cursor
      assign cur0 = 1'b0;
   end

   // ---------------- stage 1: memory read ----------------
   logic              txt1, hs1, vs1, cur1;
   logic [2:0]        gr1, px1;
   logic [7:0]        chr1, scr_rd;
   logic [ATTR_W-1:0] attr1, att_rd;
   logic              sel_q;

   txtvid_dpram #(.W(8), .DEPTH(CELLS), .AW(ADDR_W)) u_scr (
      .clk(clk), .we_a(host_we && !host_sel), .addr_a(host_addr),
      .wdata_a(host_wdata), .rdata_a(scr_rd), .addr_b(addr0), .rdata_b(chr1)
   );

   txtvid_dpram #(.W(ATTR_W), .DEPTH(CELLS), .AW(ADDR_W)) u_att (
      .clk(clk), .we_a(host_we && host_sel), .addr_a(host_addr),
      .wdata_a(host_wdata[ATTR_W-1:0]), .rdata_a(att_rd),
      .addr_b(addr0), .rdata_b(attr1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txt1 <= 1'b0;
         hs1  <= 1'b1;
         vs1  <= 1'b1;
         cur1 <= 1'b0;
         gr1  <= '0;
         px1  <= '0;
      end else begin
         txt1 <= txt0;
         hs1  <= hs0;
         vs1  <= vs0;
         cur1 <= cur0;
         gr1  <= gr0;
         px1  <= px0;
      end
   end

   always_ff @(posedge clk) sel_q <= host_sel;
   assign host_rdata = sel_q ? 8'(att_rd) : scr_rd;

   // ---------------- stage 2: glyph and pixel ----------------
   logic [GLYPH_W-1:0] gbits;
   logic               pix1;

   txtvid_glyph_rom u_rom (.code(chr1[6:0]), .row(gr1), .bits(gbits));

   assign pix1 = gbits[GLYPH_W - 1 - int'(px1)] ^ chr1[7] ^ cur1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_n <= 1'b1;
         vsync_n <= 1'b1;
         rgb     <= '0;
      end else begin
         hsync_n <= hs1;
         vsync_n <= vs1;
         rgb     <= (txt1 && pix1) ? attr1 : '0;
      end
   end

   AST_HSYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_n == $past(hs0, 2)); // R1
   AST_VSYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_n == $past(vs0, 2)); // R2
   AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(txt0, 2) |-> rgb == '0); // R3
   AST_VID_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      int'(addr0) < CELLS); // R4
endmodule

// File: tb/tb_txtvid_ctrl.sv
module tb_txtvid_ctrl;
   localparam int COLS = 4, ROWS = 3;
   localparam int HV = 32, HFP = 2, HS = 4, HBP = 2;
   localparam int VV = 52, VFP = 1, VS = 2, VBP = 1;
   localparam int HT = HV + HFP + HS + HBP;
   localparam int VT = VV + VFP + VS + VBP;
   localparam int FRAME = HT * VT;
   localparam int BLINK = 2;
   localparam int NCELL = COLS * ROWS;
   localparam int CUR_C = 2, CUR_R = 1;

   // stimulus/expected table: {character byte, attribute}, index = cell address
   localparam logic [11:0] CELL_TAB [NCELL] = '{
      12'h41F, 12'hC2A, 12'h005, 12'h7F9, 12'h10C, 12'h553,
      12'hA37, 12'h00E, 12'hFF1, 12'h3C4, 12'h286, 12'h9DB };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0, host_sel = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic [6:0] cursor_col = 7'(CUR_C);
   logic [4:0] cursor_row = 5'(CUR_R);
   logic       hsync_n, vsync_n;
   logic [3:0] rgb;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   txtvid_ctrl #(
      .COLS(COLS), .ROWS(ROWS), .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
      .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .ATTR_W(4), .ADDR_W(4),
      .COL_W(7), .ROW_W(5), .BLINK_FRAMES(BLINK), .CURSOR_EN(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cursor_col(cursor_col), .cursor_row(cursor_row),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
   );

   function automatic logic [7:0] glyph(input logic [6:0] c, input int r);
      logic [7:0] m;
      m = 8'((r * 37) % 256);
      return {1'b0, c} ^ m;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 hsync_n", int'(hsync_n), 1);
      check("R9 vsync_n", int'(vsync_n), 1);
      check("R9 rgb", int'(rgb), 0);
      // load both memories from the table
      for (int i = 0; i < NCELL; i++) begin
         host_we = 1'b1; host_sel = 1'b0; host_addr = 4'(i);
         host_wdata = CELL_TAB[i][11:4];
         @(negedge clk);
         host_sel = 1'b1; host_wdata = {4'h0, CELL_TAB[i][3:0]};
         @(negedge clk);
      end
      host_we = 1'b0;
      // R8 readback of both memories
      for (int i = 0; i < NCELL; i++) begin
         host_sel = 1'b0; host_addr = 4'(i);
         @(negedge clk);
         check("R8 screen read", int'(host_rdata), int'(CELL_TAB[i][11:4]));
         host_sel = 1'b1;
         @(negedge clk);
         check("R8 attr read", int'(host_rdata), int'(CELL_TAB[i][3:0]));
      end
      check("R9 rgb held", int'(rgb), 0);
      rst_n = 1'b1;
      // full raster comparison over five frames
      for (int m = 1; m <= 2 + 5 * FRAME; m++) begin
         @(negedge clk);
         if (m >= 2) begin
            int p, h, v, f, col, row, gr, idx, erg;
            logic [7:0] c, g;
            logic bitv, rev, cur, txt;
            string tag;
            p = m - 2;
            h = p % HT; v = (p / HT) % VT; f = p / FRAME;
            check("R1 hsync", int'(hsync_n),
                  (h >= HV + HFP && h < HV + HFP + HS) ? 0 : 1);
            check("R2 vsync", int'(vsync_n),
                  (v >= VV + VFP && v < VV + VFP + VS) ? 0 : 1);
            txt = h < HV && v < VV && v < ROWS * 16;
            erg = 0; tag = "R3";
            if (txt) begin
               col = h / 8; row = v / 16; gr = (v % 16) / 2;
               idx = row * COLS + col;
               c = CELL_TAB[idx][11:4];
               g = glyph(c[6:0], gr);
               bitv = g[7 - (h % 8)];
               rev = c[7];
               cur = (col == CUR_C) && (row == CUR_R) && ((f / BLINK) % 2 == 0);
               bitv = bitv ^ rev ^ cur;
               erg = bitv ? int'(CELL_TAB[idx][3:0]) : 0;
               if (col == CUR_C && row == CUR_R) tag = "R7 cursor";
               else if (rev) tag = "R6 reverse";
               else tag = "R4 R5 glyph";
            end
            check(tag, int'(rgb), erg);
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule